// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding and Selection

This block chooses the operands for the execute stage of a five-stage in-order pipeline. The two source register numbers held in the decode/execute register are compared with the destination register numbers of the two older instructions. Those older instructions sit in the execute/memory register and in the memory/write-back register. When a match is found, the newer value is routed to the ALU before it reaches the register file.

Each source operand has its own four-way selector. The selector picks one of three values:

- the value read from the register file,
- the ALU result waiting in the execute/memory register,
- the final write-back value.

The write-back value is formed inside the block from the load data or the ALU result of the oldest instruction. The forwarded second operand leaves the block as store data. It also feeds a two-way selector that can replace it with the immediate at the ALU's second input. The block is purely combinational, and stalling for loads is handled elsewhere.

Top module: `exfwd_operand_sel`

## Requirements
- R1: When neither older instruction forwards to an operand, that operand takes its register-file value and its select code reads 2'b00.
- R2: When only the execute/memory instruction writes a register and its destination equals the operand's non-zero address, the operand takes that stage's ALU result and its select code reads 2'b10.
- R3: When only the memory/write-back instruction writes a register and its destination equals the operand's non-zero address, the operand takes the write-back value and its select code reads 2'b01.
- R4: When both older instructions write the operand's non-zero address, the execute/memory ALU result wins and the select code reads 2'b10.
- R5: A stage whose write enable is low never forwards, even when its destination equals the operand address.
- R6: An operand address of zero always takes the register-file value with select code 2'b00, whatever the older stages hold.
- R7: The second operand follows the same selection rules independently of the first, and the store-data output always equals the forwarded second operand.
- R8: With the immediate-select input high, the ALU's second input equals the immediate; with it low, the ALU's second input equals the forwarded second operand. Store data does not depend on this input.
- R9: The write-back value equals the load data when the load-select input is high and the oldest instruction's ALU result when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_addr | input | AW | First source register number of the instruction in execute |
| ex_rt_addr | input | AW | Second source register number of the instruction in execute |
| ex_rs_val | input | DW | Register-file value for the first source |
| ex_rt_val | input | DW | Register-file value for the second source |
| ex_imm | input | DW | Extended immediate of the instruction in execute |
| ex_use_imm | input | 1 | High selects the immediate as the ALU's second input |
| mem_wr_en | input | 1 | Register write enable of the execute/memory instruction |
| mem_dst | input | AW | Destination register of the execute/memory instruction |
| mem_alu_res | input | DW | ALU result held in the execute/memory register |
| wb_wr_en | input | 1 | Register write enable of the memory/write-back instruction |
| wb_dst | input | AW | Destination register of the memory/write-back instruction |
| wb_load_data | input | DW | Data read from memory for the oldest instruction |
| wb_alu_res | input | DW | ALU result of the oldest instruction |
| wb_take_load | input | 1 | High selects load data as the write-back value |
| alu_op_a | output | DW | First ALU operand |
| alu_op_b | output | DW | Second ALU operand |
| store_data | output | DW | Forwarded second operand, sent to memory for stores |
| wb_value | output | DW | Write-back value, also returned to the register file |
| fwd_sel_a | output | 2 | Select code used for the first operand |
| fwd_sel_b | output | 2 | Select code used for the second operand |

## Verification
The bench builds the block with 3-bit register numbers (eight registers) and 16-bit data. This makes a full sweep of both source addresses, both destinations and both write enables feasible, at 16384 combinations. Every case of register-zero suppression, enable gating, single-stage matches and double matches is therefore visited for both operands. Every source value carries a distinct high nibble, so a wrong selection always shows as a wrong value. The immediate-select and load-select inputs are derived from address bits, so each of them is toggled across the whole sweep.

// File: rtl/exfwd_pkg.sv
package exfwd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WBACK   = 2'b01,
        SRC_EXMEM   = 2'b10,
        SRC_SPARE   = 2'b11
    } fwd_src_e;

    // The nearer stage holds the younger result, so it wins.
    function automatic fwd_src_e pick_src(input logic hit_exmem, input logic hit_wback);
        if (hit_exmem)      return SRC_EXMEM;
        else if (hit_wback) return SRC_WBACK;
        else                return SRC_REGFILE;
    endfunction

endpackage

// File: rtl/exfwd_detect.sv
module exfwd_detect
    import exfwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [1:0][AW-1:0] src_addr,
    input  logic               mem_wr_en,
    input  logic [AW-1:0]      mem_dst,
    input  logic               wb_wr_en,
    input  logic [AW-1:0]      wb_dst,
    output fwd_src_e [1:0]     sel
);

    localparam int NOPS = 2;

    logic [NOPS-1:0] hit_mem;
    logic [NOPS-1:0] hit_wb;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        assign hit_mem[g] = mem_wr_en && (mem_dst == src_addr[g]) && (src_addr[g] != '0);
        assign hit_wb[g]  = wb_wr_en  && (wb_dst  == src_addr[g]) && (src_addr[g] != '0);
        assign sel[g]     = pick_src(hit_mem[g], hit_wb[g]);

        always_comb begin
            if (!$isunknown({src_addr[g], mem_wr_en, mem_dst, wb_wr_en, wb_dst})) begin
                if (src_addr[g] == '0)
                    AST_ZERO_NO_FWD: assert (sel[g] == SRC_REGFILE); // R6
                if (!mem_wr_en && !wb_wr_en)
                    AST_WE_GATES_FWD: assert (sel[g] == SRC_REGFILE); // R5
                AST_SEL_LEGAL: assert (sel[g] != SRC_SPARE); // R1
            end
        end
    end

endmodule

// File: rtl/exfwd_mux4.sv
module exfwd_mux4
    import exfwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  fwd_src_e         sel,
    input  logic [DW-1:0]    regfile_val,
    input  logic [DW-1:0]    exmem_val,
    input  logic [DW-1:0]    wback_val,
    output logic [DW-1:0]    y
);

    always_comb begin
        unique case (sel)
            SRC_EXMEM: y = exmem_val;
            SRC_WBACK: y = wback_val;
            default:   y = regfile_val; // 2'b00 and the spare code
        endcase
    end

endmodule

// File: rtl/exfwd_wbsel.sv
module exfwd_wbsel #(
    parameter int DW = 32
) (
    input  logic          take_load,
    input  logic [DW-1:0] load_data,
    input  logic [DW-1:0] alu_res,
    output logic [DW-1:0] y
);

    assign y = take_load ? load_data : alu_res;

endmodule

// File: rtl/exfwd_operand_sel.sv
module exfwd_operand_sel
    import exfwd_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic [AW-1:0] ex_rs_addr,
    input  logic [AW-1:0] ex_rt_addr,
    input  logic [DW-1:0] ex_rs_val,
    input  logic [DW-1:0] ex_rt_val,
    input  logic [DW-1:0] ex_imm,
    input  logic          ex_use_imm,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] mem_dst,
    input  logic [DW-1:0] mem_alu_res,
    input  logic          wb_wr_en,
    input  logic [AW-1:0] wb_dst,
    input  logic [DW-1:0] wb_load_data,
    input  logic [DW-1:0] wb_alu_res,
    input  logic          wb_take_load,
    output logic [DW-1:0] alu_op_a,
    output logic [DW-1:0] alu_op_b,
    output logic [DW-1:0] store_data,
    output logic [DW-1:0] wb_value,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b
);

    localparam int NOPS = 2;

    logic [NOPS-1:0][AW-1:0] addr_v;
    logic [NOPS-1:0][DW-1:0] rf_v;
    logic [NOPS-1:0][DW-1:0] opnd_v;
    fwd_src_e [NOPS-1:0]     sel_v;

    assign addr_v = {ex_rt_addr, ex_rs_addr};
    assign rf_v   = {ex_rt_val, ex_rs_val};

    exfwd_wbsel #(.DW(DW)) u_wbsel (
        .take_load (wb_take_load),
        .load_data (wb_load_data),
        .alu_res   (wb_alu_res),
        .y         (wb_value)
    );

    exfwd_detect #(.AW(AW)) u_detect (
        .src_addr  (addr_v),
        .mem_wr_en (mem_wr_en),
        .mem_dst   (mem_dst),
        .wb_wr_en  (wb_wr_en),
        .wb_dst    (wb_dst),
        .sel       (sel_v)
    );

    for (genvar g = 0; g < NOPS; g++) begin : g_mux
        exfwd_mux4 #(.DW(DW)) u_mux (
            .sel         (sel_v[g]),
            .regfile_val (rf_v[g]),
            .exmem_val   (mem_alu_res),
            .wback_val   (wb_value),
            .y           (opnd_v[g])
        );
    end

    assign alu_op_a   = opnd_v[0];
    assign store_data = opnd_v[1];
    assign alu_op_b   = ex_use_imm ? ex_imm : opnd_v[1];
    assign fwd_sel_a  = sel_v[0];
    assign fwd_sel_b  = sel_v[1];

    always_comb begin
        if (!$isunknown({ex_rs_addr, ex_rt_addr, mem_wr_en, mem_dst, wb_wr_en, wb_dst,
                         mem_alu_res, ex_use_imm, opnd_v})) begin
            if (mem_wr_en && wb_wr_en && mem_dst == wb_dst && mem_dst == ex_rs_addr
                && ex_rs_addr != '0)
                AST_NEAR_STAGE_WINS: assert (alu_op_a == mem_alu_res); // R4
            if (!ex_use_imm)
                AST_STORE_MATCHES_B: assert (alu_op_b == store_data); // R8
            if (sel_v[1] == SRC_EXMEM)
                AST_B_FROM_EXMEM: assert (store_data == mem_alu_res); // R7
            if (sel_v[0] == SRC_REGFILE)
                AST_A_FROM_RF: assert (alu_op_a == ex_rs_val); // R1
        end
    end

endmodule

// File: tb/test_exfwd_operand_sel.sv
module test_exfwd_operand_sel;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NCASE = 1 << 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk; // 250 MHz

    logic [AW-1:0] ex_rs_addr, ex_rt_addr, mem_dst, wb_dst;
    logic [DW-1:0] ex_rs_val, ex_rt_val, ex_imm, mem_alu_res, wb_load_data, wb_alu_res;
    logic          ex_use_imm, mem_wr_en, wb_wr_en, wb_take_load;
    logic [DW-1:0] alu_op_a, alu_op_b, store_data, wb_value;
    logic [1:0]    fwd_sel_a, fwd_sel_b;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    exfwd_operand_sel #(.AW(AW), .DW(DW)) i_exfwd_operand_sel (
        .ex_rs_addr   (ex_rs_addr),
        .ex_rt_addr   (ex_rt_addr),
        .ex_rs_val    (ex_rs_val),
        .ex_rt_val    (ex_rt_val),
        .ex_imm       (ex_imm),
        .ex_use_imm   (ex_use_imm),
        .mem_wr_en    (mem_wr_en),
        .mem_dst      (mem_dst),
        .mem_alu_res  (mem_alu_res),
        .wb_wr_en     (wb_wr_en),
        .wb_dst       (wb_dst),
        .wb_load_data (wb_load_data),
        .wb_alu_res   (wb_alu_res),
        .wb_take_load (wb_take_load),
        .alu_op_a     (alu_op_a),
        .alu_op_b     (alu_op_b),
        .store_data   (store_data),
        .wb_value     (wb_value),
        .fwd_sel_a    (fwd_sel_a),
        .fwd_sel_b    (fwd_sel_b)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Expected select code for one operand, with the requirement it exercises.
    task automatic expect_op(input logic [AW-1:0] a, output logic [1:0] code,
                             output string tag);
        bit m_match, w_match;
        m_match = (mem_dst == a);
        w_match = (wb_dst == a);
        if (a == 0) begin
            code = 2'b00; tag = "R6";
        end else if (mem_wr_en && m_match && wb_wr_en && w_match) begin
            code = 2'b10; tag = "R4";
        end else if (mem_wr_en && m_match) begin
            code = 2'b10; tag = "R2";
        end else if (wb_wr_en && w_match) begin
            code = 2'b01; tag = "R3";
        end else if (m_match || w_match) begin
            code = 2'b00; tag = "R5";
        end else begin
            code = 2'b00; tag = "R1";
        end
    endtask

    function automatic logic [DW-1:0] val_of(input logic [1:0] code, input logic [DW-1:0] rf,
                                             input logic [DW-1:0] wbv);
        if (code == 2'b10)      return mem_alu_res;
        else if (code == 2'b01) return wbv;
        else                    return rf;
    endfunction

    initial begin
        ex_rs_addr = '0; ex_rt_addr = '0; mem_dst = '0; wb_dst = '0;
        ex_rs_val = 16'h1111; ex_rt_val = 16'h2222; ex_imm = 16'h3333;
        mem_alu_res = 16'h4444; wb_load_data = 16'h5555; wb_alu_res = 16'h6666;
        ex_use_imm = 1'b0; mem_wr_en = 1'b0; wb_wr_en = 1'b0; wb_take_load = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // Quiescent state: nothing forwards
        chk("R1", "idle sel_a", {30'd0, fwd_sel_a}, 32'd0);
        chk("R1", "idle alu_a", {16'd0, alu_op_a}, 32'h1111);
        chk("R7", "idle store", {16'd0, store_data}, 32'h2222);
        chk("R9", "idle wb", {16'd0, wb_value}, 32'h6666);

        for (int i = 0; i < NCASE; i++) begin
            logic [13:0] ix;
            logic [1:0]  ca, cb;
            string       ta, tb;
            logic [DW-1:0] wbv, ea, eb;
            @(posedge clk);
            ix = i[13:0];
            ex_rs_addr   = ix[2:0];
            ex_rt_addr   = ix[5:3];
            mem_dst      = ix[8:6];
            wb_dst       = ix[11:9];
            mem_wr_en    = ix[12];
            wb_wr_en     = ix[13];
            ex_use_imm   = ix[0] ^ ix[7];
            wb_take_load = ix[1] ^ ix[10];
            ex_rs_val    = {4'h1, ix[11:0]};
            ex_rt_val    = {4'h2, ix[11:0]};
            ex_imm       = {4'h3, ix[11:0]};
            mem_alu_res  = {4'h4, ix[11:0]};
            wb_load_data = {4'h5, ix[11:0]};
            wb_alu_res   = {4'h6, ix[11:0]};
            #1;
            wbv = wb_take_load ? wb_load_data : wb_alu_res;
            expect_op(ex_rs_addr, ca, ta);
            expect_op(ex_rt_addr, cb, tb);
            ea = val_of(ca, ex_rs_val, wbv);
            eb = val_of(cb, ex_rt_val, wbv);
            chk("R9", "wb value", {16'd0, wb_value}, {16'd0, wbv});
            chk(ta, "sel_a", {30'd0, fwd_sel_a}, {30'd0, ca});
            chk(ta, "alu_a", {16'd0, alu_op_a}, {16'd0, ea});
            chk({tb, " R7"}, "sel_b", {30'd0, fwd_sel_b}, {30'd0, cb});
            chk({tb, " R7"}, "store", {16'd0, store_data}, {16'd0, eb});
            chk("R8", "alu_b", {16'd0, alu_op_b}, {16'd0, ex_use_imm ? ex_imm : eb});
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule